// File: doc/BRIEF.md
# Direct-Mapped Write-Through Line Cache

This block is a direct-mapped cache placed between a core and a slower, word-addressed next-level memory. Each set holds one line of several 32-bit words. The core presents one request at a time. In the same cycle, the block answers with one of three results: a hit with the data, a miss with the number of cycles still to wait, or an invalid-address error. On a miss the core keeps asking, or asks again later, until the line is present.

Each set owns one fill engine. A miss to a set with no pending fill starts that engine for the line-aligned address. The engine first counts down the next level's fixed latency. It then reads the line's words from the lowest address to the highest, one word per cycle. Only when the last word has arrived does it install the line, so the old line of that set stays usable until then. If the next level replies with a stall, the engine reloads its countdown and resumes at the word it was waiting on. If the next level replies with an error, the engine keeps that error until a request for a different line restarts it. Writes allocate like reads. A write that hits updates the cached word and sends the same word to the next level in that cycle.

Top module: `dmwt_cache`

## Requirements
- R1: The byte address splits into a byte offset of log2(LINE_WORDS*4) bits at the bottom, the set index of log2(SETS) bits above it, and the tag in the remaining upper bits. Word w of a line is at offset 4*w.
- R2: A request to a set whose line is valid and whose stored tag equals the address tag raises resp_hit in the same cycle. For a read, resp_rdata carries the addressed word. At most one of resp_hit, resp_miss and resp_err is high.
- R3: A request that misses in a set with no fill pending raises resp_miss with resp_stall equal to NL_LATENCY, and opens a fill for the line-aligned address.
- R4: An open fill's countdown starts at NL_LATENCY and drops by one each cycle until it reaches 1. A miss to a set with a pending, error-free fill reports that fill's current count, and resp_stall is never 0 while resp_miss is high.
- R5: While its count is 1, the fill reads the next outstanding word of its line, one word per cycle, in ascending address order. A stall reply with count n reloads the countdown with n (1 if n is 0), and the same word is read again once the count is back at 1.
- R6: After the last word of a line is received, the set holds that tag and data, marked valid. Later requests to the line hit and return the words the next level supplied.
- R7: An error reply stops the fill and is kept. A request to the same line then gets resp_err, and the fill makes no further next-level reads.
- R8: A request to a different line while the set's fill holds an error gets resp_miss with resp_stall equal to NL_LATENCY. It clears the error and restarts the fill for the new line.
- R9: A write that misses behaves as a read miss and sends nothing to the next level. A write that hits updates the cached word and issues exactly one next-level write, with the request's address and data, in that cycle.
- R10: Reset clears every valid bit and every pending fill. With no request and no fill pending, nl_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present this cycle |
| req_write | input | 1 | Request is a word write |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| resp_hit | output | 1 | Request served this cycle |
| resp_miss | output | 1 | Line not present; retry later |
| resp_err | output | 1 | Next level reported the line invalid |
| resp_stall | output | CNT_W | Remaining wait cycles, valid with resp_miss |
| resp_rdata | output | 32 | Read data, valid with resp_hit |
| nl_req | output | 1 | Next-level word access this cycle |
| nl_we | output | 1 | Next-level access is a write |
| nl_addr | output | 32 | Next-level byte address |
| nl_wdata | output | 32 | Next-level write data |
| nl_ack | input | 1 | Next level completed the access |
| nl_stall | input | 1 | Next level is busy; retry after nl_stall_cycles |
| nl_stall_cycles | input | CNT_W | Wait reported with nl_stall |
| nl_err | input | 1 | Next level rejects the address |
| nl_rdata | input | 32 | Next-level read data |

## Verification
The embedded properties check every cycle that a fill's count is never zero and steps down by one while it waits, and that a fill holding an error never asks for a word. They also check that next-level writes occur only alongside a write hit, with matching data, and that every fresh miss leaves a fill open in its set. Things that depend on a sequence of cycles can only be shown by the bench's scenarios. These are the exact cycle of each fetched address, the resume point after a stall, the error being kept for the same line and cleared for another, the data returned after eviction and write-through, and the loss of cached lines at reset.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
   localparam int unsigned ADDR_W = 32;
   localparam int unsigned WORD_W = 32;

   typedef enum logic [1:0] {
      RK_IDLE,
      RK_HIT,
      RK_MISS,
      RK_ERR
   } rkind_e;
endpackage

// File: rtl/dmwt_addr_split.sv
module dmwt_addr_split
   import dmwt_pkg::*;
#(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned WSEL_W = 2,
   parameter int unsigned TAG_W  = 26
) (
   input  logic [ADDR_W-3:0] waddr_i,
   output logic [TAG_W-1:0]  tag_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [WSEL_W-1:0] wsel_o
);
   initial begin : split_width_chk
      assert (TAG_W + IDX_W + WSEL_W == ADDR_W - 2)
         else $error("address fields do not cover the word address");
   end

   // word select sits just above the byte bits, index above it, tag on top
   assign wsel_o = waddr_i[WSEL_W-1:0];
   assign idx_o  = waddr_i[WSEL_W +: IDX_W];
   assign tag_o  = waddr_i[ADDR_W-3 -: TAG_W];
endmodule

// File: rtl/dmwt_line_store.sv
module dmwt_line_store
   import dmwt_pkg::*;
#(
   parameter int unsigned SETS       = 16,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned WSEL_W     = 2,
   parameter int unsigned TAG_W      = 26
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic [WSEL_W-1:0]            rd_wsel,
   output logic                         rd_valid,
   output logic [TAG_W-1:0]             rd_tag,
   output logic [WORD_W-1:0]            rd_word,
   input  logic                         wr_en,
   input  logic [IDX_W-1:0]             wr_idx,
   input  logic [WSEL_W-1:0]            wr_wsel,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic                         ins_en,
   input  logic [IDX_W-1:0]             ins_idx,
   input  logic [TAG_W-1:0]             ins_tag,
   input  logic [LINE_WORDS*WORD_W-1:0] ins_line
);
   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [WORD_W-1:0] data_q [SETS][LINE_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (ins_en) begin
         valid_q[ins_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (ins_en) begin
         tag_q[ins_idx] <= ins_tag;
         for (int w = 0; w < LINE_WORDS; w++) begin
            data_q[ins_idx][w] <= ins_line[w*WORD_W +: WORD_W];
         end
      end
      if (wr_en && !(ins_en && ins_idx == wr_idx)) begin
         data_q[wr_idx][wr_wsel] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_word  = data_q[rd_idx][rd_wsel];

   // R6
   install_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |=> valid_q[$past(ins_idx)]);
endmodule

// File: rtl/dmwt_fill_slot.sv
module dmwt_fill_slot
   import dmwt_pkg::*;
#(
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned WSEL_W     = 2,
   parameter int unsigned TAG_W      = 26,
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned LATENCY    = 100
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [TAG_W-1:0]             load_tag_i,
   input  logic                         grant_i,
   input  logic                         nl_ack_i,
   input  logic                         nl_stall_i,
   input  logic [CNT_W-1:0]             nl_stall_cycles_i,
   input  logic                         nl_err_i,
   input  logic [WORD_W-1:0]            nl_rdata_i,
   output logic                         active_o,
   output logic                         err_o,
   output logic [TAG_W-1:0]             tag_o,
   output logic [CNT_W-1:0]             cnt_o,
   output logic                         want_o,
   output logic [WSEL_W-1:0]            wsel_o,
   output logic                         done_o,
   output logic [LINE_WORDS*WORD_W-1:0] line_o
);
   localparam logic [CNT_W-1:0]  LAT_C = CNT_W'(LATENCY);
   localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
   localparam logic [WSEL_W-1:0] LAST  = WSEL_W'(LINE_WORDS - 1);

   logic              act_q, err_q;
   logic [TAG_W-1:0]  tag_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WSEL_W-1:0] w_q;
   logic [WORD_W-1:0] hold_q [LINE_WORDS];
   logic              take, got;

   assign want_o = act_q && !err_q && (cnt_q == ONE_C);
   assign take   = grant_i && want_o;
   assign got    = take && !nl_err_i && !nl_stall_i && nl_ack_i;
   assign done_o = got && (w_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         err_q <= 1'b0;
         tag_q <= '0;
         cnt_q <= '0;
         w_q   <= '0;
      end else if (load_i) begin
         act_q <= 1'b1;
         err_q <= 1'b0;
         tag_q <= load_tag_i;
         cnt_q <= LAT_C;
         w_q   <= '0;
      end else if (act_q && !err_q) begin
         if (cnt_q > ONE_C) begin
            cnt_q <= cnt_q - ONE_C;
         end else if (take) begin
            if (nl_err_i) begin
               err_q <= 1'b1;
            end else if (nl_stall_i) begin
               cnt_q <= (nl_stall_cycles_i == '0) ? ONE_C : nl_stall_cycles_i;
            end else if (nl_ack_i) begin
               if (w_q == LAST) begin
                  act_q <= 1'b0;
               end else begin
                  w_q <= w_q + WSEL_W'(1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (got) begin
         hold_q[w_q] <= nl_rdata_i;
      end
   end

   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_line
      assign line_o[g*WORD_W +: WORD_W] =
         (got && w_q == WSEL_W'(g)) ? nl_rdata_i : hold_q[g];
   end

   assign active_o = act_q;
   assign err_o    = err_q;
   assign tag_o    = tag_q;
   assign cnt_o    = cnt_q;
   assign wsel_o   = w_q;

   // R4
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      act_q |-> (cnt_q != '0));
   // R4
   countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !err_q && cnt_q > ONE_C && !load_i) |=> (cnt_q == $past(cnt_q) - ONE_C));
   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !want_o);
   // R8
   load_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (!act_q || err_q));
   // R5
   grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_i |-> (act_q && cnt_q == ONE_C));
endmodule

// File: rtl/dmwt_fetch_arb.sv
module dmwt_fetch_arb #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] want_i,
   input  logic         block_i,
   output logic [N-1:0] grant_o
);
   logic found;

   // fixed priority: the lowest-numbered set that is ready takes the port
   always_comb begin
      grant_o = '0;
      found   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (want_i[i] && !found && !block_i) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache
   import dmwt_pkg::*;
#(
   parameter int unsigned SETS       = 16,
   parameter int unsigned LINE_WORDS = 4,
   parameter int unsigned NL_LATENCY = 100,
   parameter int unsigned CNT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [31:0]       req_addr,
   input  logic [31:0]       req_wdata,
   output logic              resp_hit,
   output logic              resp_miss,
   output logic              resp_err,
   output logic [CNT_W-1:0]  resp_stall,
   output logic [31:0]       resp_rdata,
   output logic              nl_req,
   output logic              nl_we,
   output logic [31:0]       nl_addr,
   output logic [31:0]       nl_wdata,
   input  logic              nl_ack,
   input  logic              nl_stall,
   input  logic [CNT_W-1:0]  nl_stall_cycles,
   input  logic              nl_err,
   input  logic [31:0]       nl_rdata
);
   localparam int unsigned WSEL_W = $clog2(LINE_WORDS);
   localparam int unsigned OFS_W  = WSEL_W + 2;
   localparam int unsigned IDX_W  = $clog2(SETS);
   localparam int unsigned TAG_W  = ADDR_W - OFS_W - IDX_W;
   localparam int unsigned LINE_W = LINE_WORDS * WORD_W;
   localparam logic [CNT_W-1:0] LAT_C = CNT_W'(NL_LATENCY);

   initial begin : param_chk
      assert (SETS >= 2 && (SETS & (SETS - 1)) == 0)
         else $error("SETS must be a power of two of at least 2");
      assert (LINE_WORDS >= 2 && (LINE_WORDS & (LINE_WORDS - 1)) == 0)
         else $error("LINE_WORDS must be a power of two of at least 2");
      assert (NL_LATENCY >= 1 && NL_LATENCY < (64'd1 << CNT_W))
         else $error("NL_LATENCY must fit the stall counter and be nonzero");
   end

   // request decode
   logic [TAG_W-1:0]  r_tag;
   logic [IDX_W-1:0]  r_idx;
   logic [WSEL_W-1:0] r_wsel;

   dmwt_addr_split #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .TAG_W(TAG_W)) i_split (
      .waddr_i (req_addr[ADDR_W-1:2]),
      .tag_o   (r_tag),
      .idx_o   (r_idx),
      .wsel_o  (r_wsel)
   );

   // per-set fill engines
   logic [SETS-1:0]   s_act, s_err, s_want, s_done, s_load, grant;
   logic [TAG_W-1:0]  s_tag  [SETS];
   logic [CNT_W-1:0]  s_cnt  [SETS];
   logic [WSEL_W-1:0] s_wsel [SETS];
   logic [LINE_W-1:0] s_line [SETS];
   logic              do_load;

   for (genvar g = 0; g < SETS; g++) begin : g_fill
      assign s_load[g] = do_load && (r_idx == IDX_W'(g));

      dmwt_fill_slot #(
         .LINE_WORDS (LINE_WORDS),
         .WSEL_W     (WSEL_W),
         .TAG_W      (TAG_W),
         .CNT_W      (CNT_W),
         .LATENCY    (NL_LATENCY)
      ) i_slot (
         .clk               (clk),
         .rst_n             (rst_n),
         .load_i            (s_load[g]),
         .load_tag_i        (r_tag),
         .grant_i           (grant[g]),
         .nl_ack_i          (nl_ack),
         .nl_stall_i        (nl_stall),
         .nl_stall_cycles_i (nl_stall_cycles),
         .nl_err_i          (nl_err),
         .nl_rdata_i        (nl_rdata),
         .active_o          (s_act[g]),
         .err_o             (s_err[g]),
         .tag_o             (s_tag[g]),
         .cnt_o             (s_cnt[g]),
         .want_o            (s_want[g]),
         .wsel_o            (s_wsel[g]),
         .done_o            (s_done[g]),
         .line_o            (s_line[g])
      );
   end

   // line storage
   logic              rd_valid;
   logic [TAG_W-1:0]  rd_tag;
   logic [WORD_W-1:0] rd_word;
   logic              wt;
   logic              ins_en;
   logic [IDX_W-1:0]  f_idx;
   logic [TAG_W-1:0]  f_tag;
   logic [WSEL_W-1:0] f_wsel;
   logic [LINE_W-1:0] ins_line;

   dmwt_line_store #(
      .SETS       (SETS),
      .LINE_WORDS (LINE_WORDS),
      .IDX_W      (IDX_W),
      .WSEL_W     (WSEL_W),
      .TAG_W      (TAG_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (r_idx),
      .rd_wsel  (r_wsel),
      .rd_valid (rd_valid),
      .rd_tag   (rd_tag),
      .rd_word  (rd_word),
      .wr_en    (wt),
      .wr_idx   (r_idx),
      .wr_wsel  (r_wsel),
      .wr_data  (req_wdata),
      .ins_en   (ins_en),
      .ins_idx  (f_idx),
      .ins_tag  (f_tag),
      .ins_line (ins_line)
   );

   // response decision
   rkind_e           rk;
   logic [CNT_W-1:0] stall_d;
   logic             hit;

   assign hit = req_valid && rd_valid && (rd_tag == r_tag);

   always_comb begin
      rk      = RK_IDLE;
      stall_d = '0;
      do_load = 1'b0;
      if (req_valid) begin
         if (hit) begin
            rk = RK_HIT;
         end else if (!s_act[r_idx]) begin
            rk      = RK_MISS;
            stall_d = LAT_C;
            do_load = 1'b1;
         end else if (s_err[r_idx]) begin
            if (s_tag[r_idx] == r_tag) begin
               rk = RK_ERR;
            end else begin
               rk      = RK_MISS;
               stall_d = LAT_C;
               do_load = 1'b1;
            end
         end else begin
            rk      = RK_MISS;
            stall_d = s_cnt[r_idx];
         end
      end
   end

   assign resp_hit   = (rk == RK_HIT);
   assign resp_miss  = (rk == RK_MISS);
   assign resp_err   = (rk == RK_ERR);
   assign resp_stall = stall_d;
   assign resp_rdata = resp_hit ? rd_word : '0;

   // next-level port: write-through has priority over fill reads
   assign wt = req_valid && req_write && (rk == RK_HIT);

   dmwt_fetch_arb #(.N(SETS)) i_arb (
      .want_i  (s_want),
      .block_i (wt),
      .grant_o (grant)
   );

   always_comb begin
      f_tag    = '0;
      f_idx    = '0;
      f_wsel   = '0;
      ins_en   = 1'b0;
      ins_line = '0;
      for (int i = 0; i < SETS; i++) begin
         if (grant[i]) begin
            f_tag    = s_tag[i];
            f_idx    = IDX_W'(i);
            f_wsel   = s_wsel[i];
            ins_en   = s_done[i];
            ins_line = s_line[i];
         end
      end
   end

   assign nl_req   = wt || (|grant);
   assign nl_we    = wt;
   assign nl_addr  = wt ? req_addr : {f_tag, f_idx, f_wsel, 2'b00};
   assign nl_wdata = req_wdata;

   // R9
   wt_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nl_req && nl_we) |-> (req_valid && req_write && resp_hit));
   // R9
   wt_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nl_req && nl_we) |-> (nl_wdata == req_wdata && nl_addr[31:2] == req_addr[31:2]));
   // R4
   miss_stall_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_miss |-> (resp_stall != '0));
   // R10
   idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid && s_act == '0) |-> !nl_req);
   // R3
   miss_opens_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_miss && !s_act[r_idx]) |=> s_act[$past(r_idx)]);
endmodule

// File: tb/test_dmwt_cache.sv
module test_dmwt_cache;
   localparam int SETS  = 4;
   localparam int WORDS = 4;
   localparam int LAT   = 6;
   localparam int CW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [31:0]   req_addr = '0, req_wdata = '0;
   logic          resp_hit, resp_miss, resp_err;
   logic [CW-1:0] resp_stall;
   logic [31:0]   resp_rdata;
   logic          nl_req, nl_we, nl_ack, nl_stall, nl_err;
   logic [31:0]   nl_addr, nl_wdata, nl_rdata;
   logic [CW-1:0] nl_stall_cycles;

   always #2 clk = ~clk;

   dmwt_cache #(.SETS(SETS), .LINE_WORDS(WORDS), .NL_LATENCY(LAT), .CNT_W(CW)) i_dmwt_cache (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_err(resp_err),
      .resp_stall(resp_stall), .resp_rdata(resp_rdata),
      .nl_req(nl_req), .nl_we(nl_we), .nl_addr(nl_addr), .nl_wdata(nl_wdata),
      .nl_ack(nl_ack), .nl_stall(nl_stall), .nl_stall_cycles(nl_stall_cycles),
      .nl_err(nl_err), .nl_rdata(nl_rdata)
   );

   // next-level memory model: 256 words, addresses >= 0x400 are invalid
   logic [31:0] mem [256];
   logic [31:0] ref_mem [256];
   logic        mem_load = 1'b1;
   logic        stall_en = 1'b0;
   logic [31:0] stall_addr = '0;
   int          stall_uses = 0;

   function automatic logic [31:0] init_word(input int i);
      return 32'h1000_0000 + i * 32'h0001_0003;
   endfunction

   always_comb begin
      nl_err          = nl_req && (nl_addr >= 32'h400);
      nl_stall        = nl_req && !nl_we && !nl_err && stall_en &&
                        (nl_addr == stall_addr) && (stall_uses == 0);
      nl_ack          = nl_req && !nl_err && !nl_stall;
      nl_rdata        = mem[nl_addr[9:2]];
      nl_stall_cycles = CW'(3);
   end

   always @(posedge clk) begin
      if (mem_load) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
      end else if (nl_req && nl_we && !nl_err) begin
         mem[nl_addr[9:2]] <= nl_wdata;
      end
      if (nl_stall) stall_uses <= stall_uses + 1;
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // vector: {write, addr, wdata, expect first response to miss}
   localparam int NV = 12;
   localparam logic [65:0] VEC [NV] = '{
      {1'b0, 32'h0000_0000, 32'h0000_0000, 1'b1},
      {1'b0, 32'h0000_0004, 32'h0000_0000, 1'b0},
      {1'b0, 32'h0000_001C, 32'h0000_0000, 1'b1},
      {1'b1, 32'h0000_0008, 32'hDEAD_0001, 1'b0},
      {1'b0, 32'h0000_0008, 32'h0000_0000, 1'b0},
      {1'b0, 32'h0000_0040, 32'h0000_0000, 1'b1},
      {1'b0, 32'h0000_0008, 32'h0000_0000, 1'b1},
      {1'b1, 32'h0000_005C, 32'hBEEF_0007, 1'b1},
      {1'b0, 32'h0000_005C, 32'h0000_0000, 1'b0},
      {1'b0, 32'h0000_03FC, 32'h0000_0000, 1'b1},
      {1'b0, 32'h0000_03F0, 32'h0000_0000, 1'b0},
      {1'b0, 32'h0000_0018, 32'h0000_0000, 1'b1}
   };

   task automatic access(input logic we, input logic [31:0] a,
                         input logic [31:0] wd, input logic exp_miss);
      int guard = 0;
      req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd;
      #1;
      // R1 R2: set/tag decode decides hit or miss
      chk(resp_miss == exp_miss, "R1", "first response miss flag", 32'(resp_miss), 32'(exp_miss));
      if (resp_miss) chk(resp_stall == CW'(LAT), "R3", "fresh miss stall", 32'(resp_stall), LAT);
      while (resp_miss && guard < 200) begin
         chk(!(nl_req && nl_we), "R9", "no next-level write while missing", 32'(nl_we), 0);
         step(); #1; guard++;
      end
      if (we) begin
         chk(resp_hit && nl_req && nl_we && nl_addr[31:2] == a[31:2] && nl_wdata == wd,
             "R9", "write-through on hit", nl_wdata, wd);
         ref_mem[a[9:2]] = wd;
      end else begin
         chk(resp_hit && resp_rdata == ref_mem[a[9:2]], "R6", "read data", resp_rdata, ref_mem[a[9:2]]);
      end
      step();
      req_valid = 1'b0; req_write = 1'b0;
      if (we) chk(mem[a[9:2]] == wd, "R9", "next level holds written word", mem[a[9:2]], wd);
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] a;
      for (int i = 0; i < 256; i++) ref_mem[i] = init_word(i);
      repeat (3) step();
      rst_n = 1'b1; mem_load = 1'b0;
      #1;
      // R10: reset state
      chk(!resp_hit && !resp_miss && !resp_err, "R10", "idle response after reset",
          {29'b0, resp_hit, resp_miss, resp_err}, 0);
      chk(!nl_req, "R10", "next level idle after reset", 32'(nl_req), 0);
      step();

      // vector walk
      for (int v = 0; v < NV; v++) begin
         access(VEC[v][65], VEC[v][64:33], VEC[v][32:1], VEC[v][0]);
      end

      // exact countdown and fetch order (set 0, tag 3)
      a = 32'h0000_00C0;
      req_valid = 1'b1; req_addr = a; #1;
      chk(resp_miss && resp_stall == CW'(LAT), "R3", "countdown start", 32'(resp_stall), LAT);
      for (int j = 1; j < LAT + WORDS; j++) begin
         int e;
         step(); #1;
         e = (j < LAT) ? (LAT - j + 1) : 1;
         chk(resp_miss && resp_stall == CW'(e), "R4", "pending fill count", 32'(resp_stall), e);
         if (j >= LAT)
            chk(nl_req && !nl_we && nl_addr == a + 32'(4 * (j - LAT)), "R5",
                "ascending fetch address", nl_addr, a + 32'(4 * (j - LAT)));
      end
      step(); #1;
      chk(resp_hit && resp_rdata == ref_mem[a[9:2]], "R6", "hit after fill", resp_rdata, ref_mem[a[9:2]]);
      step();
      req_addr = a + 32'h8; #1;
      chk(resp_hit && resp_rdata == ref_mem[(a[9:2]) + 2], "R2", "same-cycle hit other word",
          resp_rdata, ref_mem[(a[9:2]) + 2]);
      step(); req_valid = 1'b0;

      // stall reload and resume (set 0, tag 4, stall on word 2)
      a = 32'h0000_0100;
      stall_addr = a + 32'h8; stall_en = 1'b1;
      step();
      req_valid = 1'b1; req_addr = a; #1;
      chk(resp_miss, "R3", "stall line first miss", 32'(resp_miss), 1);
      for (int j = 1; j <= LAT + WORDS + 3; j++) begin
         step(); #1;
         if (j == LAT + 2)
            chk(nl_req && nl_stall && nl_addr == a + 32'h8, "R5", "stalled word address", nl_addr, a + 32'h8);
         if (j == LAT + 3)
            chk(resp_miss && resp_stall == CW'(3), "R5", "reloaded count", 32'(resp_stall), 3);
         if (j == LAT + 5)
            chk(nl_req && nl_ack && nl_addr == a + 32'h8, "R5", "resumed word address", nl_addr, a + 32'h8);
         if (j == LAT + WORDS + 2)
            chk(resp_miss, "R5", "still filling before last word", 32'(resp_miss), 1);
      end
      chk(resp_hit && resp_rdata == ref_mem[a[9:2]], "R6", "hit after stalled fill", resp_rdata, ref_mem[a[9:2]]);
      step(); req_valid = 1'b0; stall_en = 1'b0;

      // reset drops cached lines
      rst_n = 1'b0; step(); step(); rst_n = 1'b1; #1;
      chk(!resp_hit && !resp_miss && !resp_err && !nl_req, "R10", "idle after mid-run reset",
          {28'b0, nl_req, resp_hit, resp_miss, resp_err}, 0);
      step();
      req_valid = 1'b1; req_addr = a; #1;
      chk(resp_miss && resp_stall == CW'(LAT), "R10", "cached line lost at reset", 32'(resp_stall), LAT);
      step(); req_valid = 1'b0;
      repeat (LAT + WORDS + 2) step();
      #1;
      chk(!nl_req, "R10", "port idle once fill done", 32'(nl_req), 0);
      step();

      // error latch, then restart to another line (set 0)
      req_valid = 1'b1; req_addr = 32'h0000_0400; #1;
      chk(resp_miss && resp_stall == CW'(LAT), "R3", "invalid line first miss", 32'(resp_stall), LAT);
      repeat (LAT + 1) step();
      #1;
      chk(resp_err && !resp_miss, "R7", "latched error same line", 32'(resp_err), 1);
      chk(!nl_req, "R7", "no reads after error", 32'(nl_req), 0);
      step(); #1;
      chk(resp_err, "R7", "error persists", 32'(resp_err), 1);
      step();
      a = 32'h0000_0080;
      req_addr = a; #1;
      chk(resp_miss && !resp_err && resp_stall == CW'(LAT), "R8", "restart on other line",
          32'(resp_stall), LAT);
      repeat (LAT + WORDS) step();
      #1;
      chk(resp_hit && resp_rdata == ref_mem[a[9:2]], "R8", "restarted fill completes",
          resp_rdata, ref_mem[a[9:2]]);
      step();
      req_addr = 32'h0000_0400; #1;
      chk(resp_miss && !resp_err && resp_stall == CW'(LAT), "R8", "error cleared after restart",
          32'(resp_stall), LAT);
      step(); req_valid = 1'b0;
      repeat (LAT + 3) step();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule